// File: doc/BRIEF.md
# HDLC Frame Transmitter with Tagged Byte Queue

This block turns a queue of bytes into a bit-serial HDLC line signal. Each byte is pushed into a 16-entry queue along with two tag bits, end-of-packet and abort. A tag is first armed by a control write. It is then attached to the very next byte pushed, and it disarms itself when that push happens. Software can therefore queue several complete packets back to back. The engine sends each packet as follows:

- an opening flag;
- the data bytes, least significant bit first, with zero insertion;
- a 16-bit frame check sequence, sent after the end-tagged byte;
- a closing flag.

When a byte carrying the abort tag reaches the engine, the engine sends an abort run of ones instead of that byte. The line returns to idle when the queue is empty. Idle is either continuous ones or repeated flags, chosen by `mark_idle`.

The engine moves one line bit per clock and has seven states.

- **OFF**: the bit-clock enable is low. It moves to IDLE as soon as `tx_en` is high.
- **IDLE**: sends idle in 8-bit units. At the end of each unit it moves to OFF if `tx_en` is low, or to OPEN if the queue holds a byte.
- **OPEN**: sends a flag, then takes the head byte. An abort-tagged head byte leads to ABORT; any other head byte leads to DATA.
- **DATA**: sends the byte. At the end of the byte it moves to FCS if the byte was end-tagged, or to ABORT if the queue is empty or the new head is abort-tagged. Otherwise it takes the next byte and stays in DATA.
- **FCS**: sends 16 check bits, then moves to CLOSE.
- **CLOSE**: sends the closing flag. It then moves to OPEN if `tx_en` is high and another byte is queued, and to IDLE otherwise.
- **ABORT**: sends eight ones, then moves to IDLE.

Top module: `hdlc_tagged_tx`

## Requirements
- R1: A `cfg_wr` pulse without `wr_en` arms the end and abort tags from `cfg_eop` and `cfg_abort`. The next `wr_en` stores the armed tags with its byte and disarms both. A `cfg_wr` in the same cycle as `wr_en` has no effect.
- R2: The queue holds 16 entries. A `wr_en` while 16 entries are held is dropped and leaves the queue unchanged. `wr_drop` is high for exactly the one following cycle.
- R3: Each packet is sent as:
  - the flag 0x7E;
  - its bytes, each LSB first;
  - the check sequence;
  - a closing 0x7E.

  A queued following packet opens right after the closing flag. Packets leave in the order they were written.
- R4: The check sequence is the bit-reversed CRC-16 (polynomial 0x8408, shifted LSB first), preset to 0xFFFF and run over the data bits. The complement of the result is sent, low bit first.
- R5: Within data and check bits, a 0 is inserted after every five consecutive ones. This includes a pending insertion after the last check bit. Flags and abort runs get no insertion.
- R6: An abort-tagged byte is never sent. When it reaches the head at a byte boundary, the engine sends eight ones and the open frame is abandoned. The engine then idles.
- R7: If the queue is empty at the end of a non-end data byte, the frame is aborted in the same way as in R6.
- R8: With `mark_idle` = 0 the idle line is all ones. With `mark_idle` = 1 the idle line is repeated 0x7E. Idle goes out in whole 8-bit units, and a frame opens at a unit boundary.
- R9: In OFF, a high `tx_en` raises `tx_clk_en` on the next clock.
- R10: After `tx_en` falls, the frame in progress completes through its closing flag. At the following idle unit boundary, `tx_clk_en` falls and `tx_bit` rests at 1. Queued packets stay queued until `tx_en` returns.
- R11: After reset, `tx_clk_en` = 0, `tx_bit` = 1, `wr_drop` = 0, the queue is empty and no tag is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one line bit per cycle while enabled |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load the tag-arming bits |
| cfg_eop | input | 1 | End-of-packet arming value |
| cfg_abort | input | 1 | Abort arming value |
| wr_en | input | 1 | Push `wr_data` with the armed tags |
| wr_data | input | 8 | Byte to queue |
| tx_en | input | 1 | Transmitter enable |
| mark_idle | input | 1 | 0: idle ones, 1: flag fill |
| tx_bit | output | 1 | Serial line bit |
| tx_clk_en | output | 1 | High while the engine is active (bit-clock enable) |
| wr_drop | output | 1 | One-cycle pulse after a push was dropped on a full queue |

## Verification
A damaged check register appears on the line only at frame close, about 16 to 25 cycles after the fault, as a check-sequence mismatch in the received frame. A wrong run-of-ones count shows within six line bits, as a false flag or abort that splits or kills the frame. A slipped queue pointer or tag bit shows as reordered, merged or split packets at the next frame boundary. An engine stuck in the wrong idle or off state shows within one 8-bit idle unit, in the line pattern or in `tx_clk_en`.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    typedef enum logic [2:0] {
        ST_OFF, ST_IDLE, ST_OPEN, ST_DATA, ST_FCS, ST_CLOSE, ST_ABORT
    } tx_state_e;

    typedef struct packed {
        logic       abt;
        logic       eop;
        logic [7:0] data;
    } tx_entry_t;

    localparam logic [7:0]  FLAG_PAT   = 8'h7E;
    localparam logic [15:0] CRC_POLY_R = 16'h8408;
    localparam logic [15:0] CRC_PRESET = 16'hFFFF;
    localparam int          ONES_LIMIT = 5;

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic [15:0] n;
        n = c >> 1;
        if (c[0] ^ b) n = n ^ CRC_POLY_R;
        return n;
    endfunction

endpackage

// File: rtl/hdlc_tag_latch.sv
module hdlc_tag_latch
    import hdlc_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic       cfg_eop,
    input  logic       cfg_abort,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output tx_entry_t  entry
);
    logic eop_q, abt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eop_q <= 1'b0;
            abt_q <= 1'b0;
        end else if (wr_en) begin
            eop_q <= 1'b0;
            abt_q <= 1'b0;
        end else if (cfg_wr) begin
            eop_q <= cfg_eop;
            abt_q <= cfg_abort;
        end
    end

    assign entry = '{abt: abt_q, eop: eop_q, data: wr_data};

    // R1: a push always disarms both tags
    assert_tags_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!eop_q && !abt_q));

endmodule

// File: rtl/hdlc_tag_fifo.sv
module hdlc_tag_fifo
    import hdlc_tx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  tx_entry_t wr_entry,
    input  logic      pop,
    output tx_entry_t head,
    output logic      empty,
    output logic      drop
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    tx_entry_t       mem [DEPTH];
    logic [AW-1:0]   wp, rp;
    logic [CW-1:0]   cnt;
    logic            full, push;

    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);
    assign push  = wr_en && !full;
    assign head  = mem[rp];

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp   <= '0;
            rp   <= '0;
            cnt  <= '0;
            drop <= 1'b0;
        end else begin
            drop <= wr_en && full;
            if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            unique case ({push, pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    // R2: occupancy never exceeds the depth
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    // R2: a push on a full queue with no pop leaves it full
    assert_full_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !pop) |=> full);
    // R7: the engine never takes from an empty queue
    assert_no_pop_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/hdlc_tx_engine.sv
module hdlc_tx_engine
    import hdlc_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tx_en,
    input  logic      mark_idle,
    input  logic      fifo_empty,
    input  tx_entry_t head,
    output logic      pop,
    output logic      tx_bit,
    output logic      tx_clk_en
);
    tx_state_e   st, st_nxt;
    logic [3:0]  cnt;
    logic [15:0] sh, crc, crc_nx;
    logic [2:0]  ones;
    logic        cur_eop, stuff, unit_end, load, line;

    assign crc_nx = crc_step(crc, sh[0]);
    assign stuff  = (st == ST_DATA || st == ST_FCS || st == ST_CLOSE) &&
                    (ones == 3'(ONES_LIMIT));
    assign unit_end = (st != ST_OFF) && !stuff &&
                      (cnt == ((st == ST_FCS) ? 4'd15 : 4'd7));

    // next-state and queue handshake
    always_comb begin
        st_nxt = st;
        pop    = 1'b0;
        load   = 1'b0;
        unique case (st)
            ST_OFF:   if (tx_en) st_nxt = ST_IDLE;
            ST_IDLE:  if (unit_end) begin
                          if (!tx_en)           st_nxt = ST_OFF;
                          else if (!fifo_empty) st_nxt = ST_OPEN;
                      end
            ST_OPEN:  if (unit_end) begin
                          pop = 1'b1;
                          if (head.abt) st_nxt = ST_ABORT;
                          else begin load = 1'b1; st_nxt = ST_DATA; end
                      end
            ST_DATA:  if (unit_end) begin
                          if (cur_eop)         st_nxt = ST_FCS;
                          else if (fifo_empty) st_nxt = ST_ABORT;
                          else begin
                              pop = 1'b1;
                              if (head.abt) st_nxt = ST_ABORT;
                              else          load   = 1'b1;
                          end
                      end
            ST_FCS:   if (unit_end) st_nxt = ST_CLOSE;
            ST_CLOSE: if (unit_end) st_nxt = (tx_en && !fifo_empty) ? ST_OPEN : ST_IDLE;
            ST_ABORT: if (unit_end) st_nxt = ST_IDLE;
            default:  st_nxt = ST_OFF;
        endcase
    end

    // line outputs
    always_comb begin
        line = 1'b1;
        unique case (st)
            ST_OFF:           line = 1'b1;
            ST_IDLE:          line = mark_idle ? FLAG_PAT[cnt[2:0]] : 1'b1;
            ST_OPEN:          line = FLAG_PAT[cnt[2:0]];
            ST_CLOSE:         line = stuff ? 1'b0 : FLAG_PAT[cnt[2:0]];
            ST_DATA, ST_FCS:  line = stuff ? 1'b0 : sh[0];
            ST_ABORT:         line = 1'b1;
            default:          line = 1'b1;
        endcase
    end

    assign tx_bit    = line;
    assign tx_clk_en = (st != ST_OFF);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_OFF;
        else        st <= st_nxt;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            sh      <= '0;
            crc     <= CRC_PRESET;
            ones    <= '0;
            cur_eop <= 1'b0;
        end else begin
            if (unit_end)                   cnt <= '0;
            else if (!stuff && st != ST_OFF) cnt <= cnt + 4'd1;

            if (st == ST_DATA || st == ST_FCS)
                ones <= stuff ? 3'd0 : (sh[0] ? ones + 3'd1 : 3'd0);
            else
                ones <= 3'd0;

            if (st == ST_OPEN)                crc <= CRC_PRESET;
            else if (st == ST_DATA && !stuff) crc <= crc_nx;

            if (load)
                sh <= {8'h00, head.data};
            else if (st == ST_DATA && unit_end && cur_eop)
                sh <= ~crc_nx;
            else if ((st == ST_DATA || st == ST_FCS) && !stuff)
                sh <= sh >> 1;

            if (load) cur_eop <= head.eop;
        end
    end

    // checker: run of ones sent inside data and check fields
    logic [2:0] run1;
    always_ff @(posedge clk) begin
        if (!rst_n) run1 <= '0;
        else if (st == ST_DATA || st == ST_FCS)
            run1 <= tx_bit ? ((run1 == 3'd7) ? 3'd7 : run1 + 3'd1) : 3'd0;
        else
            run1 <= '0;
    end

    // R5: never more than five ones in a row inside a frame body
    assert_ones_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run1 <= 3'(ONES_LIMIT));
    // R9: enable from OFF takes effect on the next clock
    assert_start_fast_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OFF && tx_en) |=> tx_clk_en);
    // R10: the engine only stops after enable has been removed
    assert_stop_after_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_clk_en) |-> !$past(tx_en));
    // R10: stopped engine rests the line at one
    assert_rest_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_clk_en |-> tx_bit);

endmodule

// File: rtl/hdlc_tagged_tx.sv
module hdlc_tagged_tx
    import hdlc_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic       cfg_eop,
    input  logic       cfg_abort,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       tx_en,
    input  logic       mark_idle,
    output logic       tx_bit,
    output logic       tx_clk_en,
    output logic       wr_drop
);
    tx_entry_t wr_entry, head;
    logic      pop, empty;

    hdlc_tag_latch u_tags (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_eop(cfg_eop),
        .cfg_abort(cfg_abort), .wr_en(wr_en), .wr_data(wr_data), .entry(wr_entry)
    );

    hdlc_tag_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_entry(wr_entry),
        .pop(pop), .head(head), .empty(empty), .drop(wr_drop)
    );

    hdlc_tx_engine u_eng (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .mark_idle(mark_idle),
        .fifo_empty(empty), .head(head), .pop(pop),
        .tx_bit(tx_bit), .tx_clk_en(tx_clk_en)
    );

endmodule

// File: tb/hdlc_tagged_tx_tb.sv
`timescale 1ns/1ps
module hdlc_tagged_tx_tb_top;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n, cfg_wr, cfg_eop, cfg_abort, wr_en, tx_en, mark_idle;
    logic [7:0] wr_data;
    logic       tx_bit, tx_clk_en, wr_drop;

    hdlc_tagged_tx dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_eop(cfg_eop),
        .cfg_abort(cfg_abort), .wr_en(wr_en), .wr_data(wr_data),
        .tx_en(tx_en), .mark_idle(mark_idle), .tx_bit(tx_bit),
        .tx_clk_en(tx_clk_en), .wr_drop(wr_drop)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // expected and decoded traffic
    logic [7:0] exp_bytes [$];
    int         exp_len   [$];
    int         exp_abort = 0;
    logic [7:0] dec_bytes [$];
    int         dec_len   [$];
    int         dec_abort = 0, n_fcs_bad = 0, n_shape_bad = 0;
    logic [7:0] pkt [16];

    function automatic logic [15:0] ref_crc_bit(input logic [15:0] c, input logic d);
        logic fb;
        fb = c[0] ^ d;
        c  = c >> 1;
        if (fb) c = c ^ 16'h8408;
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // line receiver: flag hunt, zero deletion, abort detection
    int unsigned ones_r = 0;
    bit          in_fr = 0;
    bit          bitbuf [$];

    task automatic finish_frame();
        int nb;
        logic [7:0] by [$];
        logic [7:0] b;
        logic [15:0] c, got;
        for (int k = 0; k < 7 && bitbuf.size() > 0; k++) bitbuf.delete(bitbuf.size() - 1);
        if (bitbuf.size() == 0) return;
        if ((bitbuf.size() % 8) != 0 || bitbuf.size() < 24) begin
            n_shape_bad++;
            bitbuf.delete();
            return;
        end
        nb = bitbuf.size() / 8;
        for (int i = 0; i < nb; i++) begin
            b = 8'h00;
            for (int j = 0; j < 8; j++) b[j] = bitbuf[i*8 + j];
            by.push_back(b);
        end
        c = 16'hFFFF;
        for (int i = 0; i < nb - 2; i++)
            for (int j = 0; j < 8; j++) c = ref_crc_bit(c, by[i][j]);
        got = {by[nb-1], by[nb-2]};
        if (got != ~c) n_fcs_bad++;
        for (int i = 0; i < nb - 2; i++) dec_bytes.push_back(by[i]);
        dec_len.push_back(nb - 2);
    endtask

    always @(negedge clk) begin
        if (rst_n && tx_clk_en) begin
            if (tx_bit) begin
                ones_r++;
                if (ones_r == 7) begin
                    if (in_fr && bitbuf.size() >= 8) dec_abort++;
                    in_fr = 0;
                    bitbuf.delete();
                end else if (ones_r < 7 && in_fr) bitbuf.push_back(1'b1);
            end else begin
                if (ones_r == 5) begin
                    // inserted zero, dropped
                end else if (ones_r == 6) begin
                    if (in_fr) finish_frame();
                    in_fr = 1;
                    bitbuf.delete();
                end else if (ones_r < 5 && in_fr) bitbuf.push_back(1'b0);
                ones_r = 0;
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm(input bit e, input bit a);
        cfg_wr = 1; cfg_eop = e; cfg_abort = a;
        @(negedge clk);
        cfg_wr = 0; cfg_eop = 0; cfg_abort = 0;
    endtask

    task automatic push(input logic [7:0] d);
        wr_en = 1; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    // mode 0: end-tagged last byte, 1: abort-tagged last byte
    task automatic send_pkt(input int len, input int mode);
        for (int i = 0; i < len; i++) begin
            if (i == len - 1) arm(mode == 0, mode == 1);
            push(pkt[i]);
        end
        if (mode == 0) begin
            for (int i = 0; i < len; i++) exp_bytes.push_back(pkt[i]);
            exp_len.push_back(len);
        end else exp_abort++;
    endtask

    task automatic compare_phase(input string req, input string abreq);
        int pd = 0, pe = 0, bad;
        chk(dec_len.size() == exp_len.size(), req, "frame count",
            dec_len.size(), exp_len.size());
        for (int f = 0; f < exp_len.size() && f < dec_len.size(); f++) begin
            bad = -1;
            if (dec_len[f] != exp_len[f]) begin
                chk(0, req, $sformatf("frame %0d length", f), dec_len[f], exp_len[f]);
            end else begin
                for (int k = 0; k < exp_len[f]; k++)
                    if (bad < 0 && dec_bytes[pd+k] != exp_bytes[pe+k]) bad = k;
                chk(bad < 0, req, $sformatf("frame %0d byte %0d", f, bad),
                    (bad < 0) ? 0 : int'(dec_bytes[pd+bad]),
                    (bad < 0) ? 0 : int'(exp_bytes[pe+bad]));
            end
            pd += dec_len[f];
            pe += exp_len[f];
        end
        chk(dec_abort == exp_abort, abreq, "abort count", dec_abort, exp_abort);
        chk(n_fcs_bad == 0, "R4", "check-sequence errors", n_fcs_bad, 0);
        chk(n_shape_bad == 0, "R5", "misframed bodies", n_shape_bad, 0);
        exp_bytes.delete(); exp_len.delete(); dec_bytes.delete(); dec_len.delete();
        exp_abort = 0; dec_abort = 0; n_fcs_bad = 0; n_shape_bad = 0;
    endtask

    task automatic report();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog (all requirements): actual %0d expected %0d", 1, 0);
            report();
        end
    end

    initial begin
        int seed, zeros, allone, np, tot, len, mode;
        seed = $urandom(32'd9127);
        rst_n = 0; cfg_wr = 0; cfg_eop = 0; cfg_abort = 0; wr_en = 0;
        wr_data = 0; tx_en = 0; mark_idle = 0;
        cycles(5);
        rst_n = 1;
        cycles(2);

        // R11 reset state
        chk(tx_clk_en == 0, "R11", "tx_clk_en after reset", tx_clk_en, 0);
        chk(tx_bit == 1, "R11", "tx_bit after reset", tx_bit, 1);
        chk(wr_drop == 0, "R11", "wr_drop after reset", wr_drop, 0);

        // R9 immediate enable
        tx_en = 1;
        @(negedge clk);
        chk(tx_clk_en == 1, "R9", "tx_clk_en one clock after enable", tx_clk_en, 1);

        // R8 idle ones, then flag fill
        cycles(16);
        allone = 1;
        for (int i = 0; i < 24; i++) begin
            if (!tx_bit) allone = 0;
            @(negedge clk);
        end
        chk(allone == 1, "R8", "mark-idle off gives ones", allone, 1);
        mark_idle = 1;
        cycles(16);
        zeros = 0;
        for (int i = 0; i < 24; i++) begin
            if (!tx_bit) zeros++;
            @(negedge clk);
        end
        chk(zeros == 6, "R8", "zeros in 24 fill bits", zeros, 6);
        compare_phase("R8", "R6");

        // R1 self-clearing: A alone, then B,C as one packet
        arm(1, 0); push(8'hA1); push(8'hB2); arm(1, 0); push(8'hC3);
        exp_bytes.push_back(8'hA1); exp_len.push_back(1);
        exp_bytes.push_back(8'hB2); exp_bytes.push_back(8'hC3); exp_len.push_back(2);
        cycles(400);
        compare_phase("R1", "R6");

        // R1 arm coinciding with a push has no effect
        cfg_wr = 1; cfg_eop = 1; wr_en = 1; wr_data = 8'h3C;
        @(negedge clk);
        cfg_wr = 0; cfg_eop = 0; wr_en = 0;
        arm(1, 0); push(8'h4D);
        exp_bytes.push_back(8'h3C); exp_bytes.push_back(8'h4D); exp_len.push_back(2);
        cycles(300);
        compare_phase("R1", "R6");

        // R5 zero insertion with ones-heavy data, R3 back-to-back packets
        pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'hFF; pkt[3] = 8'h7E; pkt[4] = 8'hFC;
        send_pkt(5, 0);
        pkt[0] = 8'h00; pkt[1] = 8'h3F;
        send_pkt(2, 0);
        cycles(400);
        compare_phase("R5", "R6");

        // R7 underrun abort, then a fresh one-byte packet
        push(8'h5A);
        exp_abort = 1;
        cycles(200);
        pkt[0] = 8'h99;
        send_pkt(1, 0);
        cycles(200);
        compare_phase("R3", "R7");

        // R6 abort-tagged byte, then a clean packet
        pkt[0] = 8'h11; pkt[1] = 8'h22; pkt[2] = 8'h33;
        send_pkt(3, 1);
        pkt[0] = 8'h44;
        send_pkt(1, 0);
        cycles(300);
        compare_phase("R6", "R6");

        // R2 overflow while stopped
        mark_idle = 0;
        tx_en = 0;
        cycles(20);
        chk(tx_clk_en == 0, "R10", "engine stopped when idle and disabled", tx_clk_en, 0);
        for (int i = 0; i < 16; i++) pkt[i] = 8'(i * 17 + 3);
        send_pkt(16, 0);
        chk(wr_drop == 0, "R2", "no drop at 16th push", wr_drop, 0);
        push(8'hEE);
        chk(wr_drop == 1, "R2", "drop pulse after 17th push", wr_drop, 1);
        @(negedge clk);
        chk(wr_drop == 0, "R2", "drop pulse lasts one cycle", wr_drop, 0);
        tx_en = 1;
        cycles(500);
        compare_phase("R2", "R6");

        // R10 disable mid-frame: first packet completes, second waits
        pkt[0] = 8'h10; pkt[1] = 8'h20; pkt[2] = 8'h30; pkt[3] = 8'h40;
        send_pkt(4, 0);
        pkt[0] = 8'h55; pkt[1] = 8'hAA;
        for (int i = 0; i < 2; i++) begin
            if (i == 1) arm(1, 0);
            push(pkt[i]);
        end
        cycles(20);
        tx_en = 0;
        cycles(300);
        chk(tx_clk_en == 0, "R10", "tx_clk_en after disable", tx_clk_en, 0);
        chk(tx_bit == 1, "R10", "tx_bit rests high", tx_bit, 1);
        compare_phase("R10", "R6");
        tx_en = 1;
        exp_bytes.push_back(8'h55); exp_bytes.push_back(8'hAA); exp_len.push_back(2);
        cycles(300);
        compare_phase("R10", "R6");

        // R3/R4/R6 random packets
        for (int r = 0; r < 12; r++) begin
            mark_idle = $urandom % 2;
            cycles(16);
            np = 1 + ($urandom % 3);
            tot = 0;
            for (int p = 0; p < np; p++) begin
                len = 1 + ($urandom % 5);
                mode = (len >= 2 && ($urandom % 5) == 0) ? 1 : 0;
                for (int i = 0; i < len; i++) pkt[i] = 8'($urandom);
                send_pkt(len, mode);
                tot += len;
            end
            cycles(450);
            compare_phase("R3", "R6");
        end

        report();
    end

endmodule